// File: doc/BRIEF.md
# Debug Run-Control Request Register

This block is the write-side control register that an external debugger uses to steer a processor core. One write can ask the core to halt into debug state, ask it to resume from debug state, or ask it to drop memory transactions that block the halt. The same write can also wipe sticky status flags that live in a companion status register. Each request is caught in a flop and held on a plain output line. It stays there until the core shows, through its debug-state level, that the request is done. A write that makes no sense in the current state is dropped.

The core drives `in_debug` as a level. Other logic pulses the set inputs when sticky events occur. In the companion status register, the three exception flags sit at bits 8:6 and the pipeline-advance flag sits at bit 25. This block only holds their values. Reads of this register always return zero, so the debugger tracks halt and restart progress by polling status bits 0 and 1 elsewhere. There is no data stream, so every pin is plain control or status with no back-pressure.

Top module: `dbg_runctl`

## Requirements
- R1: A write with bit 0 set while `in_debug` is low raises `halt_req` on the next cycle. It stays high until a cycle in which `in_debug` is sampled high, and then drops on the following cycle.
- R2: A write with bit 0 set while `in_debug` is high leaves `halt_req` low.
- R3: A write with bit 1 set while `in_debug` is high raises `restart_req` on the next cycle. It stays high until `in_debug` is sampled low, and then drops on the following cycle.
- R4: A write with bit 1 set while `in_debug` is low leaves `restart_req` low.
- R5: A write with bit 4 set while `dbg_enable` is high raises `cancel_req` on the next cycle. It is held, even if `dbg_enable` later falls, until `in_debug` is sampled high. A cancel write that arrives while `in_debug` is already high leaves `cancel_req` low.
- R6: A write with bit 4 set while `dbg_enable` is low leaves `cancel_req` unchanged.
- R7: A write with bit 2 set clears all three `sticky_exc` flags on the next cycle. A write with bit 3 set clears `sticky_adv` on the next cycle. A set pulse on `exc_set[i]` or `adv_set` raises the matching flag on the next cycle.
- R8: When a set pulse and a clearing write reach the same flag in the same cycle, the flag ends up set.
- R9: `rd_data` is always zero, and bits 31:5 of a write have no effect on any output.
- R10: A synchronous active-high `rst` clears every request and every sticky flag on the next cycle.
- R11: A single write with both bit 0 and bit 1 set raises only the request that suits the current `in_debug` level: halt when the core is running, restart when it is in debug state.
- R12: While `wr_en` is low, `wr_data` has no effect.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Register write strobe |
| wr_data | input | 32 | Write word (bit 0 halt, 1 restart, 2 clear exceptions, 3 clear advance, 4 cancel) |
| rd_data | output | 32 | Read value, always zero |
| dbg_enable | input | 1 | Debug enable; gates cancel writes |
| in_debug | input | 1 | Core debug-state level |
| exc_set | input | 3 | Set pulses for the sticky exception flags |
| adv_set | input | 1 | Set pulse for the sticky pipeline-advance flag |
| halt_req | output | 1 | Held halt request |
| restart_req | output | 1 | Held restart request |
| cancel_req | output | 1 | Held abandon-transactions request |
| sticky_exc | output | 3 | Sticky exception flags (status bits 8:6) |
| sticky_adv | output | 1 | Sticky pipeline-advance flag (status bit 25) |

## Verification
The inputs change between edges. Every registered output (the three requests and the sticky flags) settles on the first rising edge after the stimulus, so its result is due one cycle later, while `rd_data` is checked in that same sample. The driver tags each expected value with the cycle number at which it falls due, which is the current count plus one. The monitor compares only at the falling edge of that cycle. Acknowledge cases work the same way: the `in_debug` level applied in one cycle is reflected in the request outputs one cycle later.

// File: rtl/dbg_runctl_pkg.sv
package dbg_runctl_pkg;
  localparam int WORD_W  = 32;
  localparam int NUM_EXC = 3;
  localparam int NUM_REQ = 3;

  localparam int BIT_HALT    = 0;
  localparam int BIT_RESTART = 1;
  localparam int BIT_CLR_EXC = 2;
  localparam int BIT_CLR_ADV = 3;
  localparam int BIT_CANCEL  = 4;
  localparam int CMD_BITS    = 5;

  localparam int REQ_HALT    = 0;
  localparam int REQ_RESTART = 1;
  localparam int REQ_CANCEL  = 2;

  typedef struct packed {
    logic cancel;
    logic clr_adv;
    logic clr_exc;
    logic restart;
    logic halt;
  } cmd_t;
endpackage

// File: rtl/dbgrc_decode.sv
module dbgrc_decode
  import dbg_runctl_pkg::*;
#(
  parameter int W = WORD_W
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         wr_en,
  input  logic [W-1:0] wr_data,
  output cmd_t         cmd
);
  localparam int RSV_W = W - CMD_BITS;

  logic [RSV_W-1:0] rsvd;
  assign rsvd = wr_data[W-1:CMD_BITS];

  always_comb begin
    cmd         = '0;
    cmd.halt    = wr_en & wr_data[BIT_HALT];
    cmd.restart = wr_en & wr_data[BIT_RESTART];
    cmd.clr_exc = wr_en & wr_data[BIT_CLR_EXC];
    cmd.clr_adv = wr_en & wr_data[BIT_CLR_ADV];
    cmd.cancel  = wr_en & wr_data[BIT_CANCEL];
  end

  // R9: reserved bits alone never produce a command
  assert_rsvd_ignored_R9: assert property (@(posedge clk) disable iff (rst)
    (wr_en && (|rsvd) && wr_data[CMD_BITS-1:0] == '0) |-> (cmd == '0));

  // R12: no strobe, no command
  assert_no_strobe_R12: assert property (@(posedge clk) disable iff (rst)
    !wr_en |-> (cmd == '0));
endmodule

// File: rtl/dbgrc_hold.sv
module dbgrc_hold #(
  parameter int N = 3
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [N-1:0] set,
  input  logic [N-1:0] ack,
  output logic [N-1:0] req
);
  for (genvar i = 0; i < N; i++) begin : g_req
    always_ff @(posedge clk) begin
      if (rst)         req[i] <= 1'b0;
      else if (ack[i]) req[i] <= 1'b0;
      else if (set[i]) req[i] <= 1'b1;
    end

    // R1 R3 R5: acknowledge drops the held request
    assert_ack_clears_R1: assert property (@(posedge clk) disable iff (rst)
      ack[i] |=> !req[i]);

    // R1 R3 R5: an accepted set raises the request
    assert_set_raises_R3: assert property (@(posedge clk) disable iff (rst)
      (set[i] && !ack[i]) |=> req[i]);

    // R5: a request is held until acknowledged
    assert_held_R5: assert property (@(posedge clk) disable iff (rst)
      (req[i] && !ack[i]) |=> req[i]);
  end
endmodule

// File: rtl/dbgrc_sticky.sv
module dbgrc_sticky #(
  parameter int N = 3
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [N-1:0] set,
  input  logic         clr,
  output logic [N-1:0] flag
);
  for (genvar i = 0; i < N; i++) begin : g_flag
    always_ff @(posedge clk) begin
      if (rst)         flag[i] <= 1'b0;
      else if (set[i]) flag[i] <= 1'b1;
      else if (clr)    flag[i] <= 1'b0;
    end

    // R8: a set pulse is never lost, even against a clear
    assert_set_wins_R8: assert property (@(posedge clk) disable iff (rst)
      set[i] |=> flag[i]);

    // R7: a clear without a set empties the flag
    assert_clear_R7: assert property (@(posedge clk) disable iff (rst)
      (clr && !set[i]) |=> !flag[i]);
  end
endmodule

// File: rtl/dbg_runctl.sv
module dbg_runctl
  import dbg_runctl_pkg::*;
(
  input  logic               clk,
  input  logic               rst,
  input  logic               wr_en,
  input  logic [WORD_W-1:0]  wr_data,
  output logic [WORD_W-1:0]  rd_data,
  input  logic               dbg_enable,
  input  logic               in_debug,
  input  logic [NUM_EXC-1:0] exc_set,
  input  logic               adv_set,
  output logic               halt_req,
  output logic               restart_req,
  output logic               cancel_req,
  output logic [NUM_EXC-1:0] sticky_exc,
  output logic               sticky_adv
);
  cmd_t               cmd;
  logic [NUM_REQ-1:0] req_set;
  logic [NUM_REQ-1:0] req_ack;
  logic [NUM_REQ-1:0] req_q;

  assign rd_data = '0;

  dbgrc_decode #(.W(WORD_W)) u_decode (
    .clk     (clk),
    .rst     (rst),
    .wr_en   (wr_en),
    .wr_data (wr_data),
    .cmd     (cmd)
  );

  always_comb begin
    req_set              = '0;
    req_ack              = '0;
    req_set[REQ_HALT]    = cmd.halt & ~in_debug;
    req_ack[REQ_HALT]    = in_debug;
    req_set[REQ_RESTART] = cmd.restart & in_debug;
    req_ack[REQ_RESTART] = ~in_debug;
    req_set[REQ_CANCEL]  = cmd.cancel & dbg_enable;
    req_ack[REQ_CANCEL]  = in_debug;
  end

  dbgrc_hold #(.N(NUM_REQ)) u_hold (
    .clk (clk),
    .rst (rst),
    .set (req_set),
    .ack (req_ack),
    .req (req_q)
  );

  assign halt_req    = req_q[REQ_HALT];
  assign restart_req = req_q[REQ_RESTART];
  assign cancel_req  = req_q[REQ_CANCEL];

  dbgrc_sticky #(.N(NUM_EXC)) u_exc (
    .clk  (clk),
    .rst  (rst),
    .set  (exc_set),
    .clr  (cmd.clr_exc),
    .flag (sticky_exc)
  );

  dbgrc_sticky #(.N(1)) u_adv (
    .clk  (clk),
    .rst  (rst),
    .set  (adv_set),
    .clr  (cmd.clr_adv),
    .flag (sticky_adv)
  );

  // R11: halt and restart are never held together
  assert_one_request_R11: assert property (@(posedge clk) disable iff (rst)
    $onehot0({halt_req, restart_req}));

  // R2: in debug state no halt request survives
  assert_halt_ignored_R2: assert property (@(posedge clk) disable iff (rst)
    in_debug |=> !halt_req);

  // R4: outside debug state no restart request survives
  assert_restart_ignored_R4: assert property (@(posedge clk) disable iff (rst)
    !in_debug |=> !restart_req);

  // R6: with debug disabled a cancel request cannot appear
  assert_cancel_gated_R6: assert property (@(posedge clk) disable iff (rst)
    (!dbg_enable && !cancel_req) |=> !cancel_req);

  // R10: reset empties every output
  assert_reset_clears_R10: assert property (@(posedge clk)
    rst |=> !(halt_req || restart_req || cancel_req || sticky_adv || (|sticky_exc)));
endmodule

// File: tb/dbg_runctl_tb.sv
module dbg_runctl_tb;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        wr_en = 1'b0;
  logic [31:0] wr_data = '0;
  logic [31:0] rd_data;
  logic        dbg_enable = 1'b0;
  logic        in_debug = 1'b0;
  logic [2:0]  exc_set = '0;
  logic        adv_set = 1'b0;
  logic        halt_req, restart_req, cancel_req, sticky_adv;
  logic [2:0]  sticky_exc;

  always #5 clk = ~clk;

  dbg_runctl u_dut (
    .clk(clk), .rst(rst), .wr_en(wr_en), .wr_data(wr_data), .rd_data(rd_data),
    .dbg_enable(dbg_enable), .in_debug(in_debug), .exc_set(exc_set),
    .adv_set(adv_set), .halt_req(halt_req), .restart_req(restart_req),
    .cancel_req(cancel_req), .sticky_exc(sticky_exc), .sticky_adv(sticky_adv)
  );

  // expected vector: {halt, restart, cancel, exc[2:0], adv}
  typedef struct {
    int          due;
    logic [6:0]  exp;
    string       tag;
  } item_t;

  item_t q[$];
  int cyc = 0;
  int n_cmp = 0;
  int n_bad = 0;
  bit done = 0;

  always @(posedge clk) cyc <= cyc + 1;

  // monitor: compare each item at the falling edge of its due cycle
  always @(negedge clk) begin
    while (q.size() > 0 && q[0].due == cyc) begin
      item_t it;
      logic [6:0] act;
      it  = q.pop_front();
      act = {halt_req, restart_req, cancel_req, sticky_exc, sticky_adv};
      n_cmp++;
      if (act !== it.exp) begin
        n_bad++;
        $display("FAIL %s cycle %0d: outputs act=%b exp=%b", it.tag, cyc, act, it.exp);
      end
      n_cmp++;
      if (rd_data !== 32'h0) begin
        n_bad++;
        $display("FAIL R9 cycle %0d: rd_data act=%h exp=00000000", cyc, rd_data);
      end
    end
  end

  // driver: apply one cycle of stimulus and queue its result
  task automatic step(input logic r, input logic w, input logic [31:0] d,
                      input logic en, input logic dbg, input logic [2:0] ex,
                      input logic adv, input logic [6:0] exp, input string tag);
    item_t it;
    @(negedge clk);
    rst = r; wr_en = w; wr_data = d; dbg_enable = en; in_debug = dbg;
    exc_set = ex; adv_set = adv;
    it.due = cyc + 1; it.exp = exp; it.tag = tag;
    q.push_back(it);
  endtask

  initial begin
    //    rst wr data          en dbg exc    adv  {h r c exc adv}
    step(1, 0, 32'h0,        0, 0, 3'b000, 0, 7'b000_000_0, "R10 reset state");
    step(0, 0, 32'h0,        0, 0, 3'b101, 1, 7'b000_101_1, "R7 sticky set");
    step(0, 1, 32'h4,        0, 0, 3'b000, 0, 7'b000_000_1, "R7 clear exc");
    step(0, 1, 32'h8,        0, 0, 3'b010, 1, 7'b000_010_1, "R8 adv set beats clear");
    step(0, 1, 32'h8,        0, 0, 3'b000, 0, 7'b000_010_0, "R7 clear adv");
    step(0, 1, 32'h4,        0, 0, 3'b001, 0, 7'b000_001_0, "R8 exc set beats clear");
    step(0, 1, 32'h1,        0, 0, 3'b000, 0, 7'b100_001_0, "R1 halt raised");
    step(0, 0, 32'h0,        0, 0, 3'b000, 0, 7'b100_001_0, "R1 halt held");
    step(0, 0, 32'h1E,       1, 0, 3'b000, 0, 7'b100_001_0, "R12 no strobe");
    step(0, 1, 32'h2,        0, 0, 3'b000, 0, 7'b100_001_0, "R4 restart ignored");
    step(0, 1, 32'h10,       0, 0, 3'b000, 0, 7'b100_001_0, "R6 cancel disabled");
    step(0, 1, 32'h10,       1, 0, 3'b000, 0, 7'b101_001_0, "R5 cancel raised");
    step(0, 0, 32'h0,        0, 0, 3'b000, 0, 7'b101_001_0, "R5 cancel held");
    step(0, 0, 32'h0,        0, 1, 3'b000, 0, 7'b000_001_0, "R1 R5 entry acks");
    step(0, 1, 32'h1,        0, 1, 3'b000, 0, 7'b000_001_0, "R2 halt ignored");
    step(0, 1, 32'h3,        0, 1, 3'b000, 0, 7'b010_001_0, "R11 both in debug");
    step(0, 0, 32'h0,        0, 1, 3'b000, 0, 7'b010_001_0, "R3 restart held");
    step(0, 0, 32'h0,        0, 0, 3'b000, 0, 7'b000_001_0, "R3 exit acks");
    step(0, 1, 32'h3,        0, 0, 3'b000, 0, 7'b100_001_0, "R11 both running");
    step(0, 1, 32'hFFFF_FFE0, 1, 0, 3'b000, 0, 7'b100_001_0, "R9 reserved ignored");
    step(1, 0, 32'h0,        0, 0, 3'b000, 0, 7'b000_000_0, "R10 reset clears");
    step(0, 1, 32'h10,       1, 1, 3'b000, 0, 7'b000_000_0, "R5 cancel in debug");
    step(0, 0, 32'h0,        0, 0, 3'b000, 0, 7'b000_000_0, "R9 idle");
    repeat (3) @(negedge clk);
    done = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    repeat (2000) @(posedge clk);
    if (!done) begin
      n_bad++;
      $display("FAIL watchdog: act=running exp=finished");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end
endmodule